// File: doc/BRIEF.md
# Movable Configuration Window Mapper

This block gives configuration-write requesters a second, relocatable 1 MB window into the 36-bit system address space. Software programs a 16-bit base (the top address bits of a 1 MB aligned region), an enable flag and a 5-bit target interface code through a small register port. Each request carries a 20-bit offset and a data word. An accepted request leaves the block one cycle later as a 36-bit address, formed by placing the base above the offset, together with the data and the target code.

A small state machine registers the outcome of each request. It has three states. `ST_IDLE` means no request was seen. `ST_ISSUE` means a translated transaction is on the outputs. `ST_REJECT` means a request was refused. The transitions are taken from any state on every clock edge:
- *req_none* goes to `ST_IDLE` when no request is present.
- *req_accept* goes to `ST_ISSUE` when the window is enabled and the target code is a valid one.
- *req_refuse* goes to `ST_REJECT` when the window is disabled or the target code is reserved.

The state register is the only sequential control. Both outputs are decoded from it.

The register port uses MSB-0 numbering on 32-bit words, so MSB-0 bit n is bit 31-n of the vector. Register writes take effect at the clock edge. A request in the same cycle as a write is judged against the values held before that write.

Top module: `cfgwin_mapper`

## Requirements
- R1: After reset both registers read as zero. The window starts disabled, so a first request is refused, and neither `out_valid` nor `out_error` is high.
- R2: Base register (`reg_sel`=0). The base sits in MSB-0 bits 8–23, which are vector bits [23:8]. All other bits ignore writes and read as 0, so writing 0xFFFFFFFF reads back 0x00FFFF00.
- R3: Attribute register (`reg_sel`=1). The enable is MSB-0 bit 0 (vector bit 31). The target code is MSB-0 bits 7–11 (vector bits [24:20]). All other bits ignore writes and read as 0, so writing 0xFFFFFFFF reads back 0x81F00000.
- R4: An accepted request produces a one-cycle `out_valid` pulse on the cycle after it. With the pulse come `out_addr` = {base, offset} (36 bits), the request data and the programmed target code.
- R5: The valid target codes are 00000, 00001, 00010, 00100, 01011, 01100, 01111 and 10110. A request made while any other code is programmed gives a one-cycle `out_error` pulse one cycle later and no `out_valid`.
- R6: A request made while the enable bit is 0 gives a one-cycle `out_error` pulse one cycle later and no `out_valid`, whatever the target code.
- R7: A cycle with no request gives neither `out_valid` nor `out_error` on the following cycle. Back-to-back requests each get their own result on consecutive cycles.
- R8: `out_valid` and `out_error` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 base, 1 attribute (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| req_valid | input | 1 | Request present |
| req_offset | input | 20 | Offset within the 1 MB window |
| req_data | input | 32 | Request data word |
| out_valid | output | 1 | Translated transaction valid (one cycle) |
| out_addr | output | 36 | Translated system address |
| out_target | output | 5 | Target interface code |
| out_data | output | 32 | Data of the translated transaction |
| out_error | output | 1 | Request refused (one cycle) |

## Verification
The bench walks every valid target code and a spread of reserved codes next to them, including the all-ones code and codes one bit away from valid ones. A decoder that trusted a bit pattern instead of the exact list would issue a reserved access or refuse a legal one. It writes all ones to both registers to catch a field placed at the wrong LSB-0 position or a reserved bit that keeps its value. A design that misread MSB-0 numbering would show it in the readback and in the address high bits. Back-to-back requests and a disable issued after an enable expose a result held over from an earlier cycle, or an enable that is sampled late.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_REJECT = 2'd2
    } win_state_e;

endpackage

// File: rtl/cfgwin_regs.sv
module cfgwin_regs #(
    parameter int REG_W    = 32,
    parameter int BASE_W   = 16,
    parameter int BASE_LSB = 8,
    parameter int EN_BIT   = 31,
    parameter int TGT_W    = 5,
    parameter int TGT_LSB  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [BASE_W-1:0] base,
    output logic              en,
    output logic [TGT_W-1:0]  tgt
);
    logic [BASE_W-1:0] base_q;
    logic              en_q;
    logic [TGT_W-1:0]  tgt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            en_q   <= 1'b0;
            tgt_q  <= '0;
        end else if (wr) begin
            if (!sel) begin
                base_q <= wdata[BASE_LSB +: BASE_W];
            end else begin
                en_q  <= wdata[EN_BIT];
                tgt_q <= wdata[TGT_LSB +: TGT_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (!sel) begin
            rdata[BASE_LSB +: BASE_W] = base_q;
        end else begin
            rdata[EN_BIT]             = en_q;
            rdata[TGT_LSB +: TGT_W]   = tgt_q;
        end
    end

    assign base = base_q;
    assign en   = en_q;
    assign tgt  = tgt_q;
endmodule

// File: rtl/cfgwin_tgt_check.sv
module cfgwin_tgt_check #(
    parameter int TGT_W = 5
) (
    input  logic [TGT_W-1:0] tgt,
    output logic             ok
);
    localparam int N_LEGAL = 8;
    localparam logic [4:0] LEGAL [N_LEGAL] = '{
        5'b00000, 5'b00001, 5'b00010, 5'b00100,
        5'b01011, 5'b01100, 5'b01111, 5'b10110
    };

    logic [N_LEGAL-1:0] hit;

    for (genvar g = 0; g < N_LEGAL; g++) begin : g_cmp
        assign hit[g] = (tgt == TGT_W'(LEGAL[g]));
    end

    assign ok = |hit;
endmodule

// File: rtl/cfgwin_fsm.sv
module cfgwin_fsm
    import cfgwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       accept,
    output logic       load,
    output logic       out_valid,
    output logic       out_error,
    output win_state_e state
);
    win_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ISSUE, ST_REJECT: begin
                if (req_valid) begin
                    state_d = accept ? ST_ISSUE : ST_REJECT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        out_valid = 1'b0;
        out_error = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ISSUE:  out_valid = 1'b1;
            ST_REJECT: out_error = 1'b1;
            default:   ;
        endcase
    end

    assign load  = req_valid && accept;
    assign state = state_q;
endmodule

// File: rtl/cfgwin_mapper.sv
module cfgwin_mapper #(
    parameter int REG_W  = 32,
    parameter int BASE_W = 16,
    parameter int OFS_W  = 20,
    parameter int TGT_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic                    reg_sel,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    input  logic                    req_valid,
    input  logic [OFS_W-1:0]        req_offset,
    input  logic [DATA_W-1:0]       req_data,
    output logic                    out_valid,
    output logic [BASE_W+OFS_W-1:0] out_addr,
    output logic [TGT_W-1:0]        out_target,
    output logic [DATA_W-1:0]       out_data,
    output logic                    out_error
);
    import cfgwin_pkg::*;

    localparam int ADDR_W   = BASE_W + OFS_W;
    localparam int BASE_LSB = 8;
    localparam int EN_BIT   = REG_W - 1;
    localparam int TGT_LSB  = REG_W - 12;

    logic [BASE_W-1:0] base_w;
    logic              en_w;
    logic [TGT_W-1:0]  tgt_w;
    logic              tgt_ok_w;
    logic              load_w;
    win_state_e        state_w;

    logic [ADDR_W-1:0] addr_q;
    logic [TGT_W-1:0]  tgt_q;
    logic [DATA_W-1:0] data_q;

    cfgwin_regs #(
        .REG_W(REG_W), .BASE_W(BASE_W), .BASE_LSB(BASE_LSB),
        .EN_BIT(EN_BIT), .TGT_W(TGT_W), .TGT_LSB(TGT_LSB)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .base(base_w), .en(en_w), .tgt(tgt_w)
    );

    cfgwin_tgt_check #(.TGT_W(TGT_W)) tchk_i (
        .tgt(tgt_w), .ok(tgt_ok_w)
    );

    cfgwin_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .accept(en_w && tgt_ok_w), .load(load_w),
        .out_valid(out_valid), .out_error(out_error), .state(state_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            tgt_q  <= '0;
            data_q <= '0;
        end else if (load_w) begin
            addr_q <= {base_w, req_offset};
            tgt_q  <= tgt_w;
            data_q <= req_data;
        end
    end

    assign out_addr   = addr_q;
    assign out_target = tgt_q;
    assign out_data   = data_q;
endmodule

// File: rtl/cfgwin_chk.sv
module cfgwin_chk #(
    parameter int REG_W  = 32,
    parameter int BASE_W = 16,
    parameter int OFS_W  = 20,
    parameter int TGT_W  = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic [OFS_W-1:0]        req_offset,
    input logic [BASE_W-1:0]       base,
    input logic                    en,
    input logic                    tgt_ok,
    input logic                    reg_sel,
    input logic [REG_W-1:0]        reg_rdata,
    input logic                    out_valid,
    input logic                    out_error,
    input logic [BASE_W+OFS_W-1:0] out_addr
);
    // R2
    base_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata[31:24] == 8'h0 && reg_rdata[7:0] == 8'h0));

    // R3
    attr_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_rdata[30:25] == 6'h0 && reg_rdata[19:0] == 20'h0));

    // R4
    accept_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && en && tgt_ok) |=>
            (out_valid && !out_error && out_addr == {$past(base), $past(req_offset)}));

    // R5
    reserved_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && en && !tgt_ok) |=> (out_error && !out_valid));

    // R6
    disabled_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !en) |=> (out_error && !out_valid));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !out_error));

    // R8
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_error));
endmodule

bind cfgwin_mapper cfgwin_chk #(
    .REG_W(REG_W), .BASE_W(BASE_W), .OFS_W(OFS_W), .TGT_W(TGT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .base(base_w), .en(en_w), .tgt_ok(tgt_ok_w), .reg_sel(reg_sel),
    .reg_rdata(reg_rdata), .out_valid(out_valid), .out_error(out_error),
    .out_addr(out_addr)
);

// File: tb/cfgwin_mapper_tb_top.sv
module cfgwin_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [19:0] req_offset = '0;
    logic [31:0] req_data = '0;
    logic        out_valid;
    logic [35:0] out_addr;
    logic [4:0]  out_target;
    logic [31:0] out_data;
    logic        out_error;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfgwin_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_offset(req_offset), .req_data(req_data), .out_valid(out_valid),
        .out_addr(out_addr), .out_target(out_target), .out_data(out_data),
        .out_error(out_error)
    );

    // fields: base[43:28] en[27] tgt[26:22] offset[21:2] kind[1:0] (0 issue, 1 refuse)
    localparam int NV = 14;
    localparam logic [43:0] VEC [NV] = '{
        {16'h0000, 1'b1, 5'b00000, 20'h00000, 2'd0},
        {16'hFFFF, 1'b1, 5'b00001, 20'hFFFFF, 2'd0},
        {16'h1234, 1'b1, 5'b00010, 20'h56789, 2'd0},
        {16'h8001, 1'b1, 5'b00100, 20'h00ABC, 2'd0},
        {16'hA5A5, 1'b1, 5'b01011, 20'h5A5A5, 2'd0},
        {16'h0F0F, 1'b1, 5'b01100, 20'hF0F0F, 2'd0},
        {16'h7FFE, 1'b1, 5'b01111, 20'h80001, 2'd0},
        {16'hC3C3, 1'b1, 5'b10110, 20'h3C3C3, 2'd0},
        {16'h1111, 1'b1, 5'b00011, 20'h11111, 2'd1},
        {16'h2222, 1'b1, 5'b00101, 20'h22222, 2'd1},
        {16'h3333, 1'b1, 5'b11111, 20'h33333, 2'd1},
        {16'h4444, 1'b1, 5'b10111, 20'h44444, 2'd1},
        {16'h5555, 1'b1, 5'b01101, 20'h55555, 2'd1},
        {16'h6666, 1'b0, 5'b00100, 20'h66666, 2'd1}
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input bit sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input bit sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    // drive one request; return at the negedge after the result edge
    task automatic req(input logic [19:0] ofs, input logic [31:0] dat);
        @(negedge clk);
        req_valid = 1'b1; req_offset = ofs; req_data = dat;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(!out_valid && !out_error, "R1 outputs idle after reset",
              {out_valid, out_error}, 0);
        rd_reg(1'b0, rd); check(rd == 0, "R1 base reads zero", rd, 0);
        rd_reg(1'b1, rd); check(rd == 0, "R1 attr reads zero", rd, 0);
        req(20'h00010, 32'hDEAD0001);
        check(out_error && !out_valid, "R1 first request refused",
              {out_valid, out_error}, 1);

        // R7: no request -> quiet next cycle
        @(negedge clk);
        check(!out_valid && !out_error, "R7 quiet without request",
              {out_valid, out_error}, 0);

        // R2/R3: reserved bits
        wr_reg(1'b0, 32'hFFFF_FFFF);
        rd_reg(1'b0, rd); check(rd == 32'h00FF_FF00, "R2 base readback mask", rd, 32'h00FF_FF00);
        wr_reg(1'b1, 32'hFFFF_FFFF);
        rd_reg(1'b1, rd); check(rd == 32'h81F0_0000, "R3 attr readback mask", rd, 32'h81F0_0000);
        wr_reg(1'b1, 32'h7E0F_FFFF);
        rd_reg(1'b1, rd); check(rd == 32'h0000_0000, "R3 only reserved bits written", rd, 0);

        // table walk: R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            logic [15:0] b; logic e; logic [4:0] t; logic [19:0] o; logic [1:0] k;
            logic [31:0] dat;
            {b, e, t, o, k} = VEC[i];
            dat = 32'hC0DE_0000 + 32'(i);
            wr_reg(1'b0, {8'h00, b, 8'h00});
            wr_reg(1'b1, {e, 6'b0, t, 20'b0});
            req(o, dat);
            if (k == 2'd0) begin
                check(out_valid && !out_error, $sformatf("R4 vec%0d issue", i),
                      {out_valid, out_error}, 2);
                check(out_addr == {b, o}, $sformatf("R4 vec%0d addr", i), out_addr, {b, o});
                check(out_target == t && out_data == dat, $sformatf("R5 vec%0d target/data", i),
                      {out_target, out_data}, {t, dat});
            end else begin
                check(out_error && !out_valid,
                      $sformatf("%s vec%0d refused", e ? "R5" : "R6", i),
                      {out_valid, out_error}, 1);
            end
            @(negedge clk);
            check(!out_valid && !out_error, $sformatf("R7 vec%0d pulse one cycle", i),
                  {out_valid, out_error}, 0);
        end

        // R7/R8: back-to-back requests with enabled window
        wr_reg(1'b0, 32'h00AB_CD00);
        wr_reg(1'b1, 32'h8000_0000);
        @(negedge clk);
        req_valid = 1'b1; req_offset = 20'h00001; req_data = 32'h1;
        @(negedge clk);
        check(out_valid && out_addr == 36'hABCD00001, "R7 back-to-back first",
              out_addr, 36'hABCD00001);
        req_offset = 20'hFFFFE; req_data = 32'h2;
        @(negedge clk);
        req_valid = 1'b0;
        check(out_valid && !out_error && out_addr == 36'hABCDFFFFE && out_data == 32'h2,
              "R8 back-to-back second", out_addr, 36'hABCDFFFFE);

        // R6: disable after enable
        wr_reg(1'b1, 32'h0000_0000);
        req(20'h00002, 32'h3);
        check(out_error && !out_valid, "R6 refused after disable",
              {out_valid, out_error}, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule